// File: doc/BRIEF.md
# Collision Pair Signal Generator

This block produces the collision-presence waveform that a medium attachment unit sends back to its station. Three sources can ask for it: a collision detected on the medium, a jabber fault, and a self-test burst that the block times by itself after each transmission when a strap input allows it. While any source is active, the output carries a square wave at the oscillator rate. When the last source goes away, the output is held high for a set number of bit times and then drops to its idle low level, and an idle flag is raised.

All timing is counted in ticks of an external enable strobe. The strobe marks the start of each oscillator period, one period per bit time. The system clock runs faster than the strobe. Each oscillator period is split into a high half of `HALF_CLKS` clocks that follows the strobe and a low half for the rest of the period. The self-test timer arms while the transmit-activity input is high. It declares the end of a transmission at the `EOT_TICKS`-th tick seen with that input low. It then waits `DELAY_TICKS` ticks and gates the wave for `BURST_TICKS` ticks. A new transmission cancels any pending or running self-test burst.

Top module: `coll_pair_gen`

## Requirements
- R1: A synchronous active-high `rst` clears all timers. From the clock edge after `rst` is sampled high, `collWave` is 0 and `collIdle` is 1.
- R2: While `collReq` is high, `collWave` carries the gated wave. Each tick period it is 1 for the `HALF_CLKS` clocks that follow the tick and 0 for the rest. `collIdle` is 0 from the first clock edge after `collReq` is sampled high. A request held for N whole tick periods gives N rising edges from the gated wave.
- R3: `jabReq` gates the wave onto `collWave` with exactly the same timing as `collReq`.
- R4: The three requests are OR-combined. Overlapping requests form one continuous active interval with no idle gap. It lasts from the first request to the end of the last one.
- R5: End of transmission is declared at the `EOT_TICKS`-th `oscTick` (default 1) that is sampled with `txActive` low after `txActive` was high. This is tick T0.
- R6: When `testEn` is 1 at T0, the self-test burst starts at tick T0+`DELAY_TICKS` (default 8). `collIdle` falls on the clock after that tick.
- R7: The self-test burst gates the wave for `BURST_TICKS` (default 8) tick periods and ends at tick T0+`DELAY_TICKS`+`BURST_TICKS`.
- R8: When `testEn` is 0 at T0, no burst is produced: `collIdle` stays 1 and `collWave` stays 0.
- R9: When `txActive` goes high during the self-test delay or burst, the burst is cancelled at the next clock edge. The timer restarts only at the next end of transmission.
- R10: When gating ends at tick b, `collWave` is held at 1 from the next clock edge. The hold lasts until the `HOLD_TICKS`-th tick after b (default 2). On the clock after that tick, `collWave` goes to 0 and `collIdle` to 1. With the bench tick spacing this is a high run of `HOLD_TICKS`*4 clocks.
- R11: `collIdle` is 1 only when no request is active and no hold is running. Whenever `collIdle` is 1, `collWave` is 0.
- R12: A request that arrives during the hold resumes gating without an idle gap. The hold restarts in full after the new request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oscTick | input | 1 | One-clock strobe at the start of each oscillator period (one bit time) |
| txActive | input | 1 | Transmit activity from the station |
| collReq | input | 1 | Collision-detect request |
| jabReq | input | 1 | Jabber-fault request |
| testEn | input | 1 | Strap enabling the post-transmission self-test burst |
| collWave | output | 1 | Gated collision waveform, idle low |
| collIdle | output | 1 | High when the output is fully idle |

## Verification
The bench builds the block with its default timing: an 8-tick delay, an 8-tick burst, a 2-tick hold, a 1-tick end-of-transmission rule and a 2-clock high half. It drives `oscTick` every 4 clocks. At this tick spacing each oscillator period is a 2-high, 2-low pattern, so the number of rising edges and the length of the final high run follow directly from the tick numbers. The short delay, burst and hold counts let the bench sweep request lengths and transmit lengths in full. They also let it place a restart of transmission inside the delay and inside the burst, and a new request inside the hold, within a few dozen ticks each.

// File: rtl/coll_pair_pkg.sv
package coll_pair_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } selfTestState_e;

  typedef struct packed {
    logic gateOn;
    logic holdOn;
  } collStrobe_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/coll_pair_ctl.sv
module coll_pair_ctl
  import coll_pair_pkg::*;
#(
  parameter int DELAY_TICKS = 8,
  parameter int BURST_TICKS = 8,
  parameter int HOLD_TICKS  = 2,
  parameter int EOT_TICKS   = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        oscTick,
  input  logic        txActive,
  input  logic        collReq,
  input  logic        jabReq,
  input  logic        testEn,
  output collStrobe_t strobes
);

  localparam int CNT_MAX = maxOf3(DELAY_TICKS, BURST_TICKS, HOLD_TICKS);
  localparam int TCNT_W  = $clog2(CNT_MAX + 1);
  localparam int EOT_W   = $clog2(EOT_TICKS + 1);

  localparam logic [TCNT_W-1:0] DELAY_LOAD = TCNT_W'(DELAY_TICKS - 1);
  localparam logic [TCNT_W-1:0] BURST_LOAD = TCNT_W'(BURST_TICKS - 1);
  localparam logic [TCNT_W-1:0] HOLD_LOAD  = TCNT_W'(HOLD_TICKS);
  localparam logic [EOT_W-1:0]  EOT_LAST   = EOT_W'(EOT_TICKS - 1);

  // end-of-transmission detection
  logic             eotArmed;
  logic [EOT_W-1:0] lowTicks;
  logic             eotHit;

  assign eotHit = oscTick && !txActive && eotArmed && (lowTicks == EOT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      eotArmed <= 1'b0;
      lowTicks <= '0;
    end else if (txActive) begin
      eotArmed <= 1'b1;
      lowTicks <= '0;
    end else if (oscTick && eotArmed) begin
      if (eotHit) begin
        eotArmed <= 1'b0;
        lowTicks <= '0;
      end else begin
        lowTicks <= lowTicks + 1'b1;
      end
    end
  end

  // self-test sequencer
  selfTestState_e    stState;
  logic [TCNT_W-1:0] stCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stState <= ST_IDLE;
      stCnt   <= '0;
    end else if (txActive) begin
      stState <= ST_IDLE;
      stCnt   <= '0;
    end else begin
      unique case (stState)
        ST_IDLE: begin
          if (eotHit && testEn) begin
            stState <= ST_WAIT;
            stCnt   <= DELAY_LOAD;
          end
        end
        ST_WAIT: begin
          if (oscTick) begin
            if (stCnt == '0) begin
              stState <= ST_BURST;
              stCnt   <= BURST_LOAD;
            end else begin
              stCnt <= stCnt - 1'b1;
            end
          end
        end
        ST_BURST: begin
          if (oscTick) begin
            if (stCnt == '0) begin
              stState <= ST_IDLE;
            end else begin
              stCnt <= stCnt - 1'b1;
            end
          end
        end
        default: begin
          stState <= ST_IDLE;
          stCnt   <= '0;
        end
      endcase
    end
  end

  // request merge and trailing hold
  logic              gateNow;
  logic              prevGate;
  logic              fallEdge;
  logic              holdActive;
  logic [TCNT_W-1:0] holdCnt;

  assign gateNow  = collReq || jabReq || (stState == ST_BURST);
  assign fallEdge = prevGate && !gateNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevGate   <= 1'b0;
      holdActive <= 1'b0;
      holdCnt    <= '0;
    end else begin
      prevGate <= gateNow;
      if (gateNow) begin
        holdActive <= 1'b0;
      end else if (fallEdge) begin
        holdActive <= 1'b1;
        holdCnt    <= HOLD_LOAD;
      end else if (holdActive && oscTick) begin
        if (holdCnt == TCNT_W'(1)) begin
          holdActive <= 1'b0;
        end
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  assign strobes.gateOn = gateNow;
  assign strobes.holdOn = holdActive || fallEdge;

endmodule

// File: rtl/coll_pair_dp.sv
module coll_pair_dp
  import coll_pair_pkg::*;
#(
  parameter int HALF_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        oscTick,
  input  collStrobe_t strobes,
  output logic        collWave,
  output logic        collIdle
);

  localparam int PH_W = $clog2(2 * HALF_CLKS + 1);
  localparam logic [PH_W-1:0] PH_TOP  = PH_W'(2 * HALF_CLKS - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_CLKS);

  logic [PH_W-1:0] phCnt;
  logic            phaseHigh;

  assign phaseHigh = (phCnt < PH_HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      phCnt <= '0;
    end else if (oscTick) begin
      phCnt <= '0;
    end else if (phCnt != PH_TOP) begin
      phCnt <= phCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      collWave <= 1'b0;
      collIdle <= 1'b1;
    end else begin
      collWave <= strobes.gateOn ? phaseHigh : strobes.holdOn;
      collIdle <= !(strobes.gateOn || strobes.holdOn);
    end
  end

endmodule

// File: rtl/coll_pair_gen.sv
module coll_pair_gen
  import coll_pair_pkg::*;
#(
  parameter int DELAY_TICKS = 8,
  parameter int BURST_TICKS = 8,
  parameter int HOLD_TICKS  = 2,
  parameter int EOT_TICKS   = 1,
  parameter int HALF_CLKS   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic oscTick,
  input  logic txActive,
  input  logic collReq,
  input  logic jabReq,
  input  logic testEn,
  output logic collWave,
  output logic collIdle
);

  collStrobe_t strobes;

  coll_pair_ctl #(
    .DELAY_TICKS(DELAY_TICKS),
    .BURST_TICKS(BURST_TICKS),
    .HOLD_TICKS (HOLD_TICKS),
    .EOT_TICKS  (EOT_TICKS)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .oscTick (oscTick),
    .txActive(txActive),
    .collReq (collReq),
    .jabReq  (jabReq),
    .testEn  (testEn),
    .strobes (strobes)
  );

  coll_pair_dp #(
    .HALF_CLKS(HALF_CLKS)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .oscTick (oscTick),
    .strobes (strobes),
    .collWave(collWave),
    .collIdle(collIdle)
  );

endmodule

// File: rtl/coll_pair_gen_chk.sv
module coll_pair_gen_chk (
  input logic clk,
  input logic rst,
  input logic collReq,
  input logic jabReq,
  input logic collWave,
  input logic collIdle
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (collIdle && !collWave));

  // R2
  coll_gates_chk: assert property (@(posedge clk) disable iff (rst)
    collReq |=> !collIdle);

  // R3
  jab_gates_chk: assert property (@(posedge clk) disable iff (rst)
    jabReq |=> !collIdle);

  // R10
  hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(collIdle) |-> $past(collWave));

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    collIdle |-> !collWave);

endmodule

bind coll_pair_gen coll_pair_gen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .collReq (collReq),
  .jabReq  (jabReq),
  .collWave(collWave),
  .collIdle(collIdle)
);

// File: tb/coll_pair_gen_bench.sv
`timescale 1ns/1ps
module coll_pair_gen_bench;

  localparam int D  = 8;
  localparam int B  = 8;
  localparam int H  = 2;
  localparam int TC = 4;   // clocks per tick

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oscTick = 1'b0;
  logic txActive = 1'b0;
  logic collReq = 1'b0;
  logic jabReq = 1'b0;
  logic testEn = 1'b1;
  logic collWave;
  logic collIdle;

  always #10 clk = ~clk;

  coll_pair_gen #(
    .DELAY_TICKS(D), .BURST_TICKS(B), .HOLD_TICKS(H), .EOT_TICKS(1), .HALF_CLKS(2)
  ) u_coll_pair_gen (
    .clk(clk), .rst(rst), .oscTick(oscTick), .txActive(txActive),
    .collReq(collReq), .jabReq(jabReq), .testEn(testEn),
    .collWave(collWave), .collIdle(collIdle)
  );

  int nChecks = 0;
  int nFails = 0;
  int tickPh = 0;
  int tickIdx = 0;
  bit done = 0;

  // interval monitor
  int nIntervals = 0;
  int fallTick = 0, riseTick = 0, rises = 0, lastRises = 0, run = 0, lastTail = 0;
  int idleBad = 0;
  logic prevIdle = 1'b1, prevWave = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      rises = 0;
      run = 0;
    end else begin
      if (collIdle && collWave) idleBad++;
      if (prevIdle && !collIdle) begin
        fallTick = tickIdx;
        rises = 0;
        run = 0;
      end
      if (!collIdle) begin
        if (collWave && !prevWave) rises++;
        run = collWave ? run + 1 : 0;
      end
      if (!prevIdle && collIdle) begin
        riseTick = tickIdx;
        lastRises = rises;
        lastTail = run;
        nIntervals++;
      end
    end
    prevIdle = collIdle;
    prevWave = collWave;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    tickPh = (tickPh + 1) % TC;
    oscTick = (tickPh == TC - 1);
    if (oscTick) tickIdx++;
  endtask

  // returns just after the posedge that consumed a tick
  task automatic alignTick();
    do step(); while (!oscTick);
    step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) alignTick();
  endtask

  task automatic checkInterval(input string tag, input int n0, input int a, input int b,
                               input bit chkRises);
    check(nIntervals == n0 + 1, {tag, " interval count"}, nIntervals, n0 + 1);
    check(fallTick == a, {tag, " start tick"}, fallTick, a);
    check(riseTick == b + H, {tag, " R10 idle tick"}, riseTick, b + H);
    check(lastTail == H * TC, {tag, " R10 hold run"}, lastTail, H * TC);
    if (chkRises) check(lastRises == b - a + 1, {tag, " rising edges"}, lastRises, b - a + 1);
  endtask

  task automatic txPulse(input int len);
    alignTick();
    txActive = 1'b1;
    ticks(len);
    txActive = 1'b0;
  endtask

  initial begin
    int n0, a, b, t0, c;
    repeat (3) step();
    // R1: reset state
    check(collIdle == 1'b1 && collWave == 1'b0, "R1 reset outputs", collIdle, 1);
    rst = 1'b0;
    ticks(2);
    check(collIdle == 1'b1 && collWave == 1'b0, "R1 idle after reset", collIdle, 1);

    // R2: collision request sweep
    for (int n = 1; n <= 4; n++) begin
      n0 = nIntervals;
      alignTick();
      a = tickIdx;
      collReq = 1'b1;
      ticks(n);
      b = tickIdx;
      collReq = 1'b0;
      ticks(H + 2);
      checkInterval("R2 collReq", n0, a, b, 1'b1);
    end

    // R3: jabber request sweep
    for (int n = 1; n <= 3; n++) begin
      n0 = nIntervals;
      alignTick();
      a = tickIdx;
      jabReq = 1'b1;
      ticks(n);
      b = tickIdx;
      jabReq = 1'b0;
      ticks(H + 2);
      checkInterval("R3 jabReq", n0, a, b, 1'b1);
    end

    // R4: overlapping requests merge
    n0 = nIntervals;
    alignTick();
    a = tickIdx;
    collReq = 1'b1;
    ticks(2);
    jabReq = 1'b1;
    ticks(1);
    collReq = 1'b0;
    ticks(2);
    b = tickIdx;
    jabReq = 1'b0;
    ticks(H + 2);
    checkInterval("R4 merged", n0, a, b, 1'b1);

    // R5 R6 R7: self-test burst for several transmit lengths
    testEn = 1'b1;
    for (int len = 1; len <= 3; len++) begin
      n0 = nIntervals;
      txPulse(len);
      t0 = tickIdx + 1;
      ticks(D + B + H + 2);
      checkInterval("R5 R6 R7 burst", n0, t0 + D, t0 + D + B, 1'b1);
    end

    // R8: strap off, no burst
    testEn = 1'b0;
    n0 = nIntervals;
    idleBad = 0;
    txPulse(2);
    ticks(D + B + H + 4);
    check(nIntervals == n0, "R8 no burst with strap off", nIntervals, n0);
    check(collIdle == 1'b1 && collWave == 1'b0, "R8 outputs idle", collIdle, 1);
    testEn = 1'b1;

    // R9: restart during delay
    n0 = nIntervals;
    txPulse(1);
    ticks(3);
    txActive = 1'b1;
    ticks(2);
    txActive = 1'b0;
    t0 = tickIdx + 1;
    ticks(D + B + H + 2);
    checkInterval("R9 cancel in delay", n0, t0 + D, t0 + D + B, 1'b1);

    // R9: restart during burst
    n0 = nIntervals;
    txPulse(1);
    t0 = tickIdx + 1;
    ticks(D + 3);
    c = tickIdx;
    txActive = 1'b1;
    ticks(H + 2);
    checkInterval("R9 cancel in burst", n0, t0 + D, c, 1'b1);
    txActive = 1'b0;
    t0 = tickIdx + 1;
    ticks(D + B + H + 2);
    checkInterval("R9 burst after restart", n0 + 1, t0 + D, t0 + D + B, 1'b1);

    // R12: request inside hold
    n0 = nIntervals;
    alignTick();
    a = tickIdx;
    collReq = 1'b1;
    ticks(2);
    collReq = 1'b0;
    ticks(1);
    collReq = 1'b1;
    ticks(2);
    b = tickIdx;
    collReq = 1'b0;
    ticks(H + 2);
    checkInterval("R12 retrigger in hold", n0, a, b, 1'b0);

    // R1: reset during burst
    n0 = nIntervals;
    txPulse(1);
    ticks(D + 2);
    check(collIdle == 1'b0, "R1 burst running before reset", collIdle, 0);
    rst = 1'b1;
    step();
    step();
    check(collIdle == 1'b1 && collWave == 1'b0, "R1 reset mid-burst", collIdle, 1);
    rst = 1'b0;
    ticks(B + H + 4);
    check(nIntervals == n0, "R1 no activity after reset", nIntervals, n0);

    // R11: wave low whenever idle
    check(idleBad == 0, "R11 wave low while idle", idleBad, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule